// File: doc/BRIEF.md
# Machine-Cycle Clock Divider with Switchback

This block turns the system clock into a machine-cycle enable: a one-clock pulse that repeats every 4, 64 or 1024 clocks, depending on a 2-bit divide code. Software asks for a new code through a write strobe. The block accepts the request only when it is legal. Any move between the two slow ratios must pass through the fast ratio (divide-by-4). Code 00 is reserved and is never accepted. While switchback is enabled and any serial activity bit is high, every write is refused.

With switchback enabled, two events return the divider to divide-by-4 on their own. A recognised interrupt sets the code to 01 on the next clock. A serial start-bit falling edge is held as pending and is applied at the next machine-cycle boundary. A changed code never shortens or stretches the machine cycle in progress. The counter picks up the new ratio only on the clock edge that ends the current cycle.

The control core is a three-state machine. ST_X4 is divide-by-4, code 01. ST_X64 is divide-by-64, code 10. ST_X1024 is divide-by-1024, code 11. The named transitions are:
- WR_SLOW: from ST_X4 to ST_X64 or ST_X1024, on an accepted write.
- WR_FAST: from ST_X64 or ST_X1024 to ST_X4, on an accepted write.
- SNAP_IRQ: from any slow state to ST_X4, on an interrupt while switchback is enabled.
- SNAP_RX: from any slow state to ST_X4, at the boundary where a pending start-bit event is applied.

Reset enters ST_X4.

Top module: `mcycle_divider`

## Requirements
- R1: After reset, div_code is 01. The first mc_tick is high during the fourth clock after reset release, on the cycle in which the counter holds 3.
- R2: mc_tick is high for exactly one clock. It repeats every 4, 64 or 1024 clocks for codes 01, 10 and 11.
- R3: A write of code 00 is ignored, and div_code keeps its value.
- R4: A write from 10 to 11, or from 11 to 10, is ignored. Writes to or from 01 are accepted.
- R5: While swb_en is 1 and any bit of ser_busy is 1, every write is ignored. With swb_en at 0, busy bits do not block a write.
- R6: An irq_ack pulse with swb_en at 1 makes div_code 01 on the next clock. With swb_en at 0, irq_ack has no effect.
- R7: An rx_start_fall pulse with swb_en at 1 leaves div_code unchanged until the next mc_tick. On the clock that ends that machine cycle, div_code becomes 01 and the 4-clock ratio starts. With swb_en at 0, the pulse has no effect.
- R8: A change of div_code takes effect on the counter only at a machine-cycle boundary. The cycle in progress completes at its old length.
- R9: An accepted write shows on div_code one clock after the strobe.
- R10: An interrupt snap in the same cycle as a write wins, and div_code becomes 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for a new divide code |
| wr_code | input | 2 | Requested code: 01 = /4, 10 = /64, 11 = /1024, 00 reserved |
| swb_en | input | 1 | Switchback enable |
| irq_ack | input | 1 | Interrupt recognised pulse |
| rx_start_fall | input | 1 | Serial start-bit falling-edge pulse |
| ser_busy | input | ACT_W | Serial transmit/receive activity bits |
| div_code | output | 2 | Current divide code |
| mc_tick | output | 1 | Machine-cycle enable pulse |

## Verification
The assertions check the following on every cycle:
- div_code never shows the reserved code.
- div_code never moves directly between the two slow codes.
- An enabled interrupt always lands on code 01.
- A refused write under serial activity leaves the code unchanged.
- mc_tick never lasts two clocks.
- The counter's active ratio changes only on a tick.
- A pending start-bit event is applied at the boundary.

Only the bench scenarios can show the following:
- The exact spacing of ticks for each ratio.
- The partial cycle that completes at its old length after a write.
- The delay of the start-bit snap to the following boundary.
- The effect of clearing swb_en.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    typedef enum logic [1:0] {
        CODE_RSVD  = 2'b00,
        CODE_X4    = 2'b01,
        CODE_X64   = 2'b10,
        CODE_X1024 = 2'b11
    } dcode_t;

    typedef enum logic [1:0] {
        ST_X4    = 2'd0,
        ST_X64   = 2'd1,
        ST_X1024 = 2'd2
    } mode_t;

    function automatic logic [1:0] mode_to_code(mode_t m);
        logic [1:0] c;
        unique case (m)
            ST_X4:    c = CODE_X4;
            ST_X64:   c = CODE_X64;
            ST_X1024: c = CODE_X1024;
            default:  c = CODE_X4;
        endcase
        return c;
    endfunction

    function automatic mode_t code_to_mode(logic [1:0] c);
        mode_t m;
        unique case (c)
            CODE_X64:   m = ST_X64;
            CODE_X1024: m = ST_X1024;
            default:    m = ST_X4;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mcd_wr_gate.sv
module mcd_wr_gate
    import mcd_pkg::*;
#(
    parameter int ACT_W = 4
) (
    input  logic             wr_en,
    input  logic [1:0]       wr_code,
    input  mode_t            cur_mode,
    input  logic             swb_en,
    input  logic [ACT_W-1:0] ser_busy,
    output logic             wr_ok,
    output mode_t            wr_mode
);

    logic code_valid;
    logic path_legal;
    logic busy_block;

    always_comb begin
        code_valid = (wr_code != CODE_RSVD);
        wr_mode    = code_to_mode(wr_code);
        // Slow-to-slow moves must go through the fast ratio.
        path_legal = (cur_mode == ST_X4) || (wr_mode == ST_X4) || (wr_mode == cur_mode);
        busy_block = swb_en && (|ser_busy);
        wr_ok      = wr_en && code_valid && path_legal && !busy_block;
    end

endmodule

// File: rtl/mcd_mode_fsm.sv
module mcd_mode_fsm
    import mcd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_ok,
    input  mode_t wr_mode,
    input  logic  swb_en,
    input  logic  irq_ack,
    input  logic  rx_start_fall,
    input  logic  tick,
    output mode_t state_q,
    output mode_t state_nxt,
    output logic  pend_q
);

    logic  irq_snap;
    logic  rx_apply;
    logic  pend_nxt;

    always_comb begin
        irq_snap = swb_en && irq_ack;
        rx_apply = pend_q && tick;
        pend_nxt = (pend_q && !tick) || (swb_en && rx_start_fall);
    end

    // Next-state logic, one arm per state
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_X4: begin
                // WR_SLOW: only a write leaves the fast state
                if (!irq_snap && !rx_apply && wr_ok) begin
                    state_nxt = wr_mode;
                end
            end
            ST_X64, ST_X1024: begin
                if (irq_snap) begin
                    state_nxt = ST_X4;          // SNAP_IRQ
                end else if (rx_apply) begin
                    state_nxt = ST_X4;          // SNAP_RX
                end else if (wr_ok && (wr_mode == ST_X4)) begin
                    state_nxt = ST_X4;          // WR_FAST
                end
            end
            default: state_nxt = ST_X4;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_X4;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_nxt;
            pend_q  <= pend_nxt;
        end
    end

    p_irq_snap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (swb_en && irq_ack) |=> (state_q == ST_X4));

    p_rx_apply_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && tick) |=> (state_q == ST_X4));

    p_slow_hop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_X64) |=> (state_q != ST_X1024));

endmodule

// File: rtl/mcd_tick_gen.sv
module mcd_tick_gen
    import mcd_pkg::*;
#(
    parameter int R_FAST = 4,
    parameter int R_MID  = 64,
    parameter int R_SLOW = 1024
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t next_mode,
    output logic  tick,
    output mode_t active_q
);

    localparam int CNT_W = $clog2(R_SLOW);
    localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(R_FAST - 1);
    localparam logic [CNT_W-1:0] LIM_MID  = CNT_W'(R_MID - 1);
    localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(R_SLOW - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        unique case (active_q)
            ST_X64:   limit = LIM_MID;
            ST_X1024: limit = LIM_SLOW;
            default:  limit = LIM_FAST;
        endcase
        tick = (cnt_q == limit);
    end

    // The ratio is sampled only on the boundary edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= ST_X4;
        end else if (tick) begin
            cnt_q    <= '0;
            active_q <= next_mode;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_ratio_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(active_q));

endmodule

// File: rtl/mcycle_divider.sv
module mcycle_divider
    import mcd_pkg::*;
#(
    parameter int ACT_W  = 4,
    parameter int R_FAST = 4,
    parameter int R_MID  = 64,
    parameter int R_SLOW = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_code,
    input  logic             swb_en,
    input  logic             irq_ack,
    input  logic             rx_start_fall,
    input  logic [ACT_W-1:0] ser_busy,
    output logic [1:0]       div_code,
    output logic             mc_tick
);

    mode_t state_q;
    mode_t state_nxt;
    mode_t wr_mode;
    mode_t active_q;
    logic  wr_ok;
    logic  pend_q;

    mcd_wr_gate #(.ACT_W(ACT_W)) u_gate (
        .wr_en    (wr_en),
        .wr_code  (wr_code),
        .cur_mode (state_q),
        .swb_en   (swb_en),
        .ser_busy (ser_busy),
        .wr_ok    (wr_ok),
        .wr_mode  (wr_mode)
    );

    mcd_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_ok         (wr_ok),
        .wr_mode       (wr_mode),
        .swb_en        (swb_en),
        .irq_ack       (irq_ack),
        .rx_start_fall (rx_start_fall),
        .tick          (mc_tick),
        .state_q       (state_q),
        .state_nxt     (state_nxt),
        .pend_q        (pend_q)
    );

    mcd_tick_gen #(.R_FAST(R_FAST), .R_MID(R_MID), .R_SLOW(R_SLOW)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .next_mode (state_nxt),
        .tick      (mc_tick),
        .active_q  (active_q)
    );

    // Output process
    always_comb begin
        div_code = mode_to_code(state_q);
    end

    p_code_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        div_code != 2'b00);

    p_no_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_code != $past(div_code)) |-> ($past(div_code) == 2'b01 || div_code == 2'b01));

    p_busy_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && swb_en && (|ser_busy) && !irq_ack && !(pend_q && mc_tick))
        |=> $stable(div_code));

endmodule

// File: tb/sim_mcycle_divider.sv
module sim_mcycle_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_code = 2'b01;
    logic       swb_en = 1'b0;
    logic       irq_ack = 1'b0;
    logic       rx_start_fall = 1'b0;
    logic [3:0] ser_busy = 4'b0;
    logic [1:0] div_code;
    logic       mc_tick;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    mcycle_divider u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
        .swb_en(swb_en), .irq_ack(irq_ack), .rx_start_fall(rx_start_fall),
        .ser_busy(ser_busy), .div_code(div_code), .mc_tick(mc_tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_code(input string req, input logic [1:0] exp);
        chk(div_code === exp, req, int'(div_code), int'(exp));
    endtask

    task automatic wait_tick();
        @(negedge clk);
        while (mc_tick !== 1'b1) @(negedge clk);
    endtask

    // Count negedges until the next sampled tick
    task automatic count_to_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (mc_tick !== 1'b1);
    endtask

    task automatic pulse_write(input logic [1:0] c);
        wr_en = 1'b1;
        wr_code = c;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        int n;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_code("R1 reset code", 2'b01);
        chk(mc_tick == 1'b0, "R1 no tick at release", int'(mc_tick), 0);
        count_to_tick(n);
        chk(n == 3, "R1 first tick position", n, 3);
        count_to_tick(n);
        chk(n == 4, "R2 period at 01", n, 4);
        @(negedge clk);
        chk(mc_tick == 1'b0, "R2 single-clock tick", int'(mc_tick), 0);
    endtask

    task automatic t_boundary();
        int n;
        wait_tick();
        @(negedge clk);
        pulse_write(2'b10);
        chk_code("R9 write seen next clock", 2'b10);
        count_to_tick(n);
        chk(n == 2, "R8 old cycle completes", n, 2);
        count_to_tick(n);
        chk(n == 64, "R2 period at 10", n, 64);
    endtask

    task automatic t_paths();
        int n;
        pulse_write(2'b11);
        chk_code("R4 10 to 11 ignored", 2'b10);
        pulse_write(2'b00);
        chk_code("R3 reserved ignored at 10", 2'b10);
        pulse_write(2'b01);
        chk_code("R4 10 to 01 accepted", 2'b01);
        pulse_write(2'b11);
        chk_code("R4 01 to 11 accepted", 2'b11);
        wait_tick();
        count_to_tick(n);
        chk(n == 1024, "R2 period at 11", n, 1024);
        pulse_write(2'b10);
        chk_code("R4 11 to 10 ignored", 2'b11);
        pulse_write(2'b00);
        chk_code("R3 reserved ignored at 11", 2'b11);
    endtask

    task automatic t_busy();
        swb_en = 1'b1;
        ser_busy = 4'b0100;
        pulse_write(2'b01);
        chk_code("R5 blocked while busy", 2'b11);
        swb_en = 1'b0;
        pulse_write(2'b01);
        chk_code("R5 accepted with swb off", 2'b01);
        ser_busy = 4'b0;
    endtask

    task automatic t_irq();
        pulse_write(2'b10);
        chk_code("R9 to 10", 2'b10);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk_code("R6 irq ignored swb off", 2'b10);
        swb_en = 1'b1;
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk_code("R6 irq snap", 2'b01);
        wr_en = 1'b1;
        wr_code = 2'b11;
        irq_ack = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        irq_ack = 1'b0;
        chk_code("R10 snap beats write", 2'b01);
        swb_en = 1'b0;
    endtask

    task automatic t_rx();
        int n;
        pulse_write(2'b10);
        wait_tick();
        wait_tick();
        @(negedge clk);
        rx_start_fall = 1'b1;
        @(negedge clk);
        rx_start_fall = 1'b0;
        chk_code("R7 no change before boundary, swb off", 2'b10);
        wait_tick();
        @(negedge clk);
        chk_code("R7 no snap with swb off", 2'b10);
        swb_en = 1'b1;
        rx_start_fall = 1'b1;
        @(negedge clk);
        rx_start_fall = 1'b0;
        repeat (10) @(negedge clk);
        chk_code("R7 held until boundary", 2'b10);
        wait_tick();
        @(negedge clk);
        chk_code("R7 snap at boundary", 2'b01);
        count_to_tick(n);
        chk(n == 3, "R7 fast ratio from boundary", n, 3);
        swb_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_boundary();
        t_paths();
        t_busy();
        t_irq();
        t_rx();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule